// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit drives the memory side of a multi-register load or store. A single start pulse hands it a base byte address, a 16-bit mask that selects registers, a two-bit ordering mode, a load/store flag and a write-back enable. For each register picked by the mask, the unit then issues one memory request per cycle. Each request carries the register number and the word address for that register. Register numbers come out in ascending order. The addresses come out in the sequence that the ordering mode produces.

When the last request has been accepted, the unit raises done for one cycle. If write-back was requested, it also presents the updated base in that same cycle. A low memory-ready holds the current request unchanged. The memory, the register file and the data path sit outside this unit. The surrounding logic pairs each request with the matching register through the index it carries.

Top module: `blk_xfer_seq`

## Requirements
- R1: After synchronous reset the unit is idle: busy, request valid, done and write-back valid are all low.
- R2: Mode 0 (ascending, step after) gives the base as the first address, and each later request is 4 bytes above the one before it.
- R3: Mode 1 (ascending, step before) gives base+4 as the first address, and each later request is 4 bytes higher.
- R4: Mode 2 (descending, step after) gives the base as the first address, and each later request is 4 bytes below the one before it.
- R5: Mode 3 (descending, step before) gives base-4 as the first address, and each later request is 4 bytes lower. For example, base 24 with mask bits 1..3 gives addresses 20, 16 and 12.
- R6: Exactly one request is issued per set mask bit (bit i selects register i). Indices come out in strictly ascending order.
- R7: While memory-ready is low, the pending request stays valid with its index and address unchanged.
- R8: An all-zero mask issues no request, and done goes high in the cycle after start.
- R9: With write-back enabled, write-back valid goes high together with done. The new base is the old base plus (modes 0 and 1) or minus (modes 2 and 3) four times the number of set mask bits. With write-back disabled, write-back valid stays low.
- R10: A start pulse that arrives while busy is ignored. The running transfer continues unchanged, and no second transfer follows it.
- R11: Busy is high from the cycle after start through the done cycle. Done is a single-cycle pulse, and busy is low in the cycle after done.
- R12: The load/store flag captured at start is presented with every request of that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| base_i | input | 32 | Base byte address |
| mask_i | input | 16 | Register selection mask |
| mode_i | input | 2 | Ordering mode 0..3 |
| is_load_i | input | 1 | 1 = load, 0 = store |
| wb_en_i | input | 1 | Write-back enable |
| mem_ready_i | input | 1 | Memory accepts the current request |
| req_valid_o | output | 1 | Request valid |
| req_load_o | output | 1 | Request is a load |
| req_idx_o | output | 4 | Register index of the request |
| req_addr_o | output | 32 | Byte address of the request |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished (one cycle) |
| wb_valid_o | output | 1 | Updated base is valid |
| wb_base_o | output | 32 | Updated base value |

## Verification
The bench aims at the pre-step offset in each mode. A design that mixes up step-before and step-after would be one word off on every address. It also aims at descending modes combined with ascending indices; swapping the index order there would pair each register with the wrong slot. Stall patterns check that an address which advanced while ready was low would drop or repeat a word. An empty mask checks that the unit neither hangs nor issues a stray request. Other runs cover a full mask, the top and bottom register alone, base wrap below zero, and a start pulse injected mid-transfer, which would corrupt or relaunch a transfer that lacked busy gating.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        XM_UP_POST   = 2'd0,
        XM_UP_PRE    = 2'd1,
        XM_DOWN_POST = 2'd2,
        XM_DOWN_PRE  = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       is_load;
        logic       wb_en;
    } xfer_ctl_t;

    function automatic logic mode_up(input xfer_mode_e m);
        return (m == XM_UP_POST) || (m == XM_UP_PRE);
    endfunction

    function automatic logic mode_pre(input xfer_mode_e m);
        return (m == XM_UP_PRE) || (m == XM_DOWN_PRE);
    endfunction

endpackage

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [NREG-1:0]  pend_next_o
);
    // lowest pending register goes first
    always_comb begin
        idx_o = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign pend_next_o = pend_i & (pend_i - NREG'(1));

endmodule

// File: rtl/blkxfer_addr.sv
module blkxfer_addr
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   mask_i,
    input  xfer_mode_e        mode_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] wb_base_o
);
    localparam int CNT_W = $clog2(NREG + 1);
    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(WORD_BYTES);

    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] span;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) cnt = cnt + CNT_W'(mask_i[i]);
    end

    assign span = ADDR_W'(cnt) * WORD;

    always_comb begin
        if (mode_up(mode_i)) begin
            wb_base_o = base_i + span;
            first_o   = mode_pre(mode_i) ? base_i + WORD : base_i;
        end else begin
            wb_base_o = base_i - span;
            first_o   = mode_pre(mode_i) ? base_i - WORD : base_i;
        end
    end

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   mask_i,
    input  logic [1:0]        mode_i,
    input  logic              is_load_i,
    input  logic              wb_en_i,
    input  logic              mem_ready_i,
    output logic              req_valid_o,
    output logic              req_load_o,
    output logic [$clog2(NREG)-1:0] req_idx_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_base_o
);
    localparam int IDX_W = $clog2(NREG);
    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(WORD_BYTES);

    seq_state_e        state_q;
    logic [NREG-1:0]   pend_q, pend_next;
    logic [ADDR_W-1:0] addr_q, wb_q, first_addr, wb_calc, step;
    xfer_ctl_t         ctl_q;
    xfer_mode_e        mode_in;

    assign mode_in = xfer_mode_e'(mode_i);

    blkxfer_addr #(.ADDR_W(ADDR_W), .NREG(NREG)) u_addr (
        .base_i    (base_i),
        .mask_i    (mask_i),
        .mode_i    (mode_in),
        .first_o   (first_addr),
        .wb_base_o (wb_calc)
    );

    blkxfer_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
        .pend_i      (pend_q),
        .idx_o       (req_idx_o),
        .pend_next_o (pend_next)
    );

    assign step = mode_up(ctl_q.mode) ? WORD : ('0 - WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            wb_q    <= '0;
            ctl_q   <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (start_i) begin
                    pend_q        <= mask_i;
                    addr_q        <= first_addr;
                    wb_q          <= wb_calc;
                    ctl_q.mode    <= mode_in;
                    ctl_q.is_load <= is_load_i;
                    ctl_q.wb_en   <= wb_en_i;
                    state_q       <= (mask_i != '0) ? SQ_RUN : SQ_FIN;
                end
                SQ_RUN: if (mem_ready_i) begin
                    pend_q <= pend_next;
                    addr_q <= addr_q + step;
                    if (pend_next == '0) state_q <= SQ_FIN;
                end
                SQ_FIN:  state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign req_valid_o = (state_q == SQ_RUN);
    assign req_load_o  = ctl_q.is_load;
    assign req_addr_o  = addr_q;
    assign busy_o      = (state_q != SQ_IDLE);
    assign done_o      = (state_q == SQ_FIN);
    assign wb_valid_o  = done_o && ctl_q.wb_en;
    assign wb_base_o   = wb_q;

    // R7: stalled request holds steady
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !mem_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_idx_o)));

    // R6: indices strictly ascending within a transfer
    p_idx_asc_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && mem_ready_i) |=> (!req_valid_o || (req_idx_o > $past(req_idx_o))));

    // R2: ascending modes step up by one word
    p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && mem_ready_i && mode_up(ctl_q.mode)) |=>
        (!req_valid_o || (req_addr_o == $past(req_addr_o) + WORD)));

    // R4: descending modes step down by one word
    p_down_step_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && mem_ready_i && !mode_up(ctl_q.mode)) |=>
        (!req_valid_o || (req_addr_o == $past(req_addr_o) - WORD)));

    // R8: empty mask finishes next cycle without a request
    p_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && (mask_i == '0)) |=> (done_o && !req_valid_o));

    // R9: write-back only alongside done
    p_wb_done_r9: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> done_o);

    // R11: done is a single pulse and ends busy
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    // R10: start while busy does not disturb a running transfer
    p_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (start_i && req_valid_o && !mem_ready_i) |=> $stable(req_addr_o));

endmodule

// File: tb/blk_xfer_seq_bench.sv
`timescale 1ns/1ps
module blk_xfer_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] mask_i = '0;
    logic [1:0]  mode_i = '0;
    logic        is_load_i = 1'b0;
    logic        wb_en_i = 1'b0;
    logic        mem_ready_i = 1'b0;
    logic        req_valid_o, req_load_o, busy_o, done_o, wb_valid_o;
    logic [3:0]  req_idx_o;
    logic [31:0] req_addr_o, wb_base_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    blk_xfer_seq u_blk_xfer_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
        .mask_i(mask_i), .mode_i(mode_i), .is_load_i(is_load_i),
        .wb_en_i(wb_en_i), .mem_ready_i(mem_ready_i),
        .req_valid_o(req_valid_o), .req_load_o(req_load_o),
        .req_idx_o(req_idx_o), .req_addr_o(req_addr_o), .busy_o(busy_o),
        .done_o(done_o), .wb_valid_o(wb_valid_o), .wb_base_o(wb_base_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // behavioural model: queue of expected requests built from the requirements
    task automatic run_xfer(input logic [31:0] base, input logic [15:0] mask,
                            input logic [1:0] mode, input bit ld, input bit wb,
                            input bit stall, input bit poke, input string tag);
        int          q_idx[$];
        logic [31:0] q_addr[$];
        logic [31:0] a;
        logic [31:0] exp_wb;
        int          n;
        int          cyc;
        bit          up;
        up = (mode < 2);
        n = 0;
        a = base;
        if (mode == 2'd1) a = base + 32'd4;
        if (mode == 2'd3) a = base - 32'd4;
        for (int i = 0; i < 16; i++) begin
            if (mask[i]) begin
                q_idx.push_back(i);
                q_addr.push_back(a);
                a = up ? a + 32'd4 : a - 32'd4;
                n++;
            end
        end
        exp_wb = up ? base + 32'(4 * n) : base - 32'(4 * n);

        @(negedge clk);
        start_i = 1'b1; base_i = base; mask_i = mask; mode_i = mode;
        is_load_i = ld; wb_en_i = wb; mem_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; base_i = 32'hFFFF_FFF0; mask_i = 16'hA5A5;
        mode_i = ~mode; is_load_i = ~ld; wb_en_i = ~wb;
        cyc = 0;
        forever begin
            check({"R11 busy ", tag}, 32'(busy_o), 32'd1);
            if (q_idx.size() != 0) begin
                check({"R6 valid ", tag}, 32'(req_valid_o), 32'd1);
                check({"R6 index ", tag}, 32'(req_idx_o), 32'(q_idx[0]));
                check({tag, " address"}, req_addr_o, q_addr[0]);
                check({"R12 load ", tag}, 32'(req_load_o), 32'(ld));
                check({"R11 done early ", tag}, 32'(done_o), 32'd0);
                mem_ready_i = stall ? ((cyc % 3) != 1) : 1'b1;
                if (mem_ready_i) begin
                    void'(q_idx.pop_front());
                    void'(q_addr.pop_front());
                end
                if (poke && cyc == 1) begin
                    start_i = 1'b1; mask_i = 16'h0001; base_i = 32'hDEAD_0000; // R10
                end else begin
                    start_i = 1'b0;
                end
            end else begin
                check({"R8 no request ", tag}, 32'(req_valid_o), 32'd0);
                check({"R11 done ", tag}, 32'(done_o), 32'd1);
                check({"R9 wb valid ", tag}, 32'(wb_valid_o), 32'(wb));
                if (wb) check({"R9 wb base ", tag}, wb_base_o, exp_wb);
                start_i = 1'b0;
                break;
            end
            cyc++;
            @(negedge clk);
        end
        @(negedge clk);
        check({"R11 busy after ", tag}, 32'(busy_o), 32'd0);
        check({"R10 done after ", tag}, 32'(done_o), 32'd0);
        check({"R10 no relaunch ", tag}, 32'(req_valid_o), 32'd0);
        mem_ready_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 busy", 32'(busy_o), 32'd0);
        check("R1 valid", 32'(req_valid_o), 32'd0);
        check("R1 done", 32'(done_o), 32'd0);
        check("R1 wb", 32'(wb_valid_o), 32'd0);

        run_xfer(32'h0000_0100, 16'h000E, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
        run_xfer(32'h0000_0100, 16'h000E, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        run_xfer(32'h0000_0100, 16'h000E, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
        run_xfer(32'd24,        16'h000E, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        run_xfer(32'h0000_2000, 16'hFFFF, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R7 R2");
        run_xfer(32'h0000_2000, 16'hFFFF, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, "R7 R5");
        run_xfer(32'h0000_0040, 16'h8000, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 top");
        run_xfer(32'h0000_0040, 16'h0001, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R4 bottom");
        run_xfer(32'h0000_0000, 16'h8421, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, "R5 wrap");
        run_xfer(32'h0000_0300, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 empty");
        run_xfer(32'h0000_0300, 16'h0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R8 empty nowb");
        run_xfer(32'h0000_1000, 16'h0F0F, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, "R10 R3");
        run_xfer(32'h0000_1000, 16'h5050, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, "R10 R4");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule